// File: doc/BRIEF.md
# UART Receive Byte Buffer with Overrun and Character Timeout

This block sits between a serial deserializer and the host register file of a 16550-style UART receiver. Each byte the deserializer delivers is stored in a small first-in first-out queue. The host sees the oldest byte on a show-ahead read port and removes it with a pop strobe. When buffering is switched off, a single holding register takes the place of the queue.

The block keeps the receive status bits: data ready, overrun and break. Overrun is raised when a byte arrives and there is no place for it. With the queue full, the new byte is thrown away and the stored bytes are kept. In single-register mode, the new byte overwrites an unread one.

A character-timeout timer counts reference ticks while the queue holds data. It raises a timeout request when four character times pass with no byte received and no byte read. The character time is the bit period, set by a divisor in reference ticks, multiplied by the frame length. The frame length comes from the programmed line format.

Top module: `rx_char_buffer`

## Requirements
- R1: In buffered mode, bytes leave in arrival order. `rd_data` shows the oldest stored byte, each accepted `rd_pop` removes it, and `fill` gives the number of stored bytes, from 0 to DEPTH.
- R2: In buffered mode, a byte that arrives while `fill` equals DEPTH and no pop is accepted in the same cycle is dropped. The stored bytes and their order stay unchanged, and `overrun` is set on the next cycle.
- R3: In single-register mode (`fifo_en`=0), a byte that arrives while `data_ready` is set, with no `rd_pop` in that cycle, sets `overrun`. The new byte replaces the held one, and `data_ready` stays 1.
- R4: In buffered mode, `data_ready` is 1 exactly when `fill` is non-zero. A pop that removes the last byte clears both `data_ready` and `brk_flag`.
- R5: In buffered mode with data stored, `timeout_irq` rises once 4 × frame × divisor reference ticks have passed since the last received byte or accepted pop. Either of those events clears it and restarts the count.
- R6: Frame length in bits is 1 start bit, plus 5 + `line_fmt[1:0]` data bits, plus 1 when `line_fmt[3]` (parity enable) is set, plus 1 stop bit, or 2 stop bits when `line_fmt[2]` is set.
- R7: While `divisor` is 0, the latched divisor and frame length keep their previous values.
- R8: `lsr_rd` clears `overrun` and `brk_flag` on the next cycle. An overrun or break event in the same cycle takes priority and keeps its bit set.
- R9: A `fifo_clr` pulse, or any change of `fifo_en`, empties the queue and the holding register. On the next cycle `fill` is 0 and `data_ready` is 0.
- R10: The timeout counter is cleared and `timeout_irq` stays 0 while the queue is empty or single-register mode is selected.
- R11: After reset, `fill`, `data_ready`, `overrun`, `brk_flag` and `timeout_irq` are 0. The divisor is DEF_DIV and the frame is 10 bits (8 data bits, no parity, 1 stop bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects buffered mode, 0 selects single-register mode |
| fifo_clr | input | 1 | Pulse that empties the queue and the holding register |
| divisor | input | DIV_W | Bit period in reference ticks; 0 keeps the previous setting |
| line_fmt | input | 4 | [1:0] data bits minus 5, [2] two stop bits, [3] parity enable |
| ref_tick | input | 1 | Reference tick enable for the timeout counter |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_data | input | DW | Received byte |
| rx_break | input | 1 | Break condition detected on the line |
| rd_pop | input | 1 | Host reads the receive register |
| lsr_rd | input | 1 | Host reads the line status |
| rd_data | output | DW | Oldest byte (buffered mode) or the held byte |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | A byte arrived with nowhere to go |
| brk_flag | output | 1 | Break indication |
| timeout_irq | output | 1 | Character timeout request |
| fill | output | CW | Number of bytes stored in the queue |

## Verification
The queue is filled to exact capacity and then sent one extra byte. Draining it afterwards shows whether a full-queue arrival was dropped or whether it overwrote or shifted the stored bytes. Timeout intervals are measured at the two frame settings of 10 and 12 bits. A zero divisor is programmed while the format is changed, which separates a correct frame formula and correct divisor latching from off-by-one timers. Single-register overwrites, break and overrun clearing, and flushes through both `fifo_clr` and a mode change are driven against a behavioural queue model that is compared on every cycle.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   localparam int FMT_W = 4;

   // Frame length: start + data (5..8) + optional parity + 1 or 2 stop bits.
   function automatic logic [3:0] frame_bits(input logic [FMT_W-1:0] fmt);
      logic [3:0] n;
      n = 4'd1 + 4'd5 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]};
      n = n + (fmt[2] ? 4'd2 : 4'd1);
      return n;
   endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr_nx;
         if (pop)  rptr <= rptr_nx;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   assign head = mem[rptr];
endmodule

// File: rtl/rxb_timer.sv
module rxb_timer #(
   parameter int DIV_W   = 16,
   parameter int DEF_DIV = 12,
   localparam int LW     = DIV_W + 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ref_tick,
   input  logic [DIV_W-1:0]         divisor,
   input  logic [rxb_pkg::FMT_W-1:0] fmt,
   input  logic                     run,
   input  logic                     restart,
   output logic                     expired
);
   logic [DIV_W-1:0] div_q;
   logic [3:0]       frame_q;
   logic [LW-1:0]    limit, cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= DIV_W'(DEF_DIV);
         frame_q <= 4'd10;
      end else if (divisor != '0) begin
         div_q   <= divisor;
         frame_q <= rxb_pkg::frame_bits(fmt);
      end
   end

   assign limit = (LW'(div_q) * LW'(frame_q)) << 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (!run || restart) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (!expired && ref_tick) begin
         if (cnt == limit - 1'b1) expired <= 1'b1;
         else                     cnt     <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
   parameter int DEPTH   = 16,
   parameter int DW      = 8,
   parameter int DIV_W   = 16,
   parameter int DEF_DIV = 12,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fifo_en,
   input  logic                      fifo_clr,
   input  logic [DIV_W-1:0]          divisor,
   input  logic [rxb_pkg::FMT_W-1:0] line_fmt,
   input  logic                      ref_tick,
   input  logic                      rx_valid,
   input  logic [DW-1:0]             rx_data,
   input  logic                      rx_break,
   input  logic                      rd_pop,
   input  logic                      lsr_rd,
   output logic [DW-1:0]             rd_data,
   output logic                      data_ready,
   output logic                      overrun,
   output logic                      brk_flag,
   output logic                      timeout_irq,
   output logic [CW-1:0]             fill
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_char_buffer: DEPTH must be at least 2");
      end
      if (DW < 5) begin : g_bad_dw
         $error("rx_char_buffer: DW must hold a 5-bit character");
      end
      if (DIV_W < 1 || DEF_DIV < 1 || DEF_DIV >= (1 << DIV_W)) begin : g_bad_div
         $error("rx_char_buffer: DEF_DIV must be non-zero and fit DIV_W");
      end
   endgenerate

   logic          mode_q, flush;
   logic          full, nonempty;
   logic          f_push, f_pop, f_ovr, h_ovr;
   logic [DW-1:0] head, hold;
   logic          hold_v, ovr_q, brk_q;

   assign flush    = fifo_clr | (fifo_en != mode_q);
   assign full     = (fill == CW'(DEPTH));
   assign nonempty = (fill != '0);
   assign f_pop    = mode_q & ~flush & rd_pop & nonempty;
   assign f_push   = mode_q & ~flush & rx_valid & ~full;
   assign f_ovr    = mode_q & ~flush & rx_valid & full;
   assign h_ovr    = ~mode_q & ~flush & rx_valid & hold_v & ~rd_pop;

   rxb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(f_push), .pop(f_pop),
      .din(rx_data), .head(head), .count(fill)
   );

   rxb_timer #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .divisor(divisor),
      .fmt(line_fmt), .run(mode_q & nonempty & ~flush),
      .restart((mode_q & rx_valid) | f_pop), .expired(timeout_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         hold   <= '0;
         hold_v <= 1'b0;
         ovr_q  <= 1'b0;
         brk_q  <= 1'b0;
      end else begin
         mode_q <= fifo_en;
         if (flush) begin
            hold_v <= 1'b0;
         end else if (!mode_q) begin
            if (rx_valid) begin
               hold   <= rx_data;
               hold_v <= 1'b1;
            end else if (rd_pop) begin
               hold_v <= 1'b0;
            end
         end
         ovr_q <= f_ovr | h_ovr | (ovr_q & ~lsr_rd);
         brk_q <= rx_break | (brk_q & ~lsr_rd & ~(f_pop && fill == CW'(1)));
      end
   end

   assign rd_data    = mode_q ? head : hold;
   assign data_ready = mode_q ? nonempty : hold_v;
   assign overrun    = ovr_q;
   assign brk_flag   = brk_q;
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fifo_en,
   input logic          fifo_clr,
   input logic          rx_valid,
   input logic [DW-1:0] rx_data,
   input logic          rx_break,
   input logic          rd_pop,
   input logic          lsr_rd,
   input logic [DW-1:0] rd_data,
   input logic          data_ready,
   input logic          overrun,
   input logic          brk_flag,
   input logic          timeout_irq,
   input logic [CW-1:0] fill,
   input logic          mode_q
);
   // R1
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

   // R2
   full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && fifo_en && !fifo_clr && fill == CW'(DEPTH) && rx_valid && !rd_pop)
      |=> (fill == CW'(DEPTH) && overrun && $stable(rd_data)));

   // R3
   hold_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !fifo_en && !fifo_clr && data_ready && rx_valid && !rd_pop)
      |=> (overrun && data_ready && rd_data == $past(rx_data)));

   // R8
   lsr_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_valid) |=> !overrun);

   // R8
   lsr_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_break) |=> !brk_flag);

   // R9
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (fill == '0 && !data_ready));

   // R10
   tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_irq |-> (data_ready && mode_q));
endmodule

bind rx_char_buffer rxb_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
   .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
   .rd_pop(rd_pop), .lsr_rd(lsr_rd), .rd_data(rd_data),
   .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag),
   .timeout_irq(timeout_irq), .fill(fill), .mode_q(mode_q)
);

// File: tb/sim_rx_char_buffer.sv
`timescale 1ns/1ps
module sim_rx_char_buffer;
   localparam int DEPTH = 16, DW = 8, DIV_W = 16, DEF_DIV = 12;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 0, rst_n = 0;
   logic fifo_en = 0, fifo_clr = 0, ref_tick = 1;
   logic [DIV_W-1:0] divisor = 1;
   logic [3:0] line_fmt = 4'b0011;
   logic rx_valid = 0, rx_break = 0, rd_pop = 0, lsr_rd = 0;
   logic [DW-1:0] rx_data = 0;
   logic [DW-1:0] rd_data;
   logic data_ready, overrun, brk_flag, timeout_irq;
   logic [CW-1:0] fill;

   int compared = 0, mismatched = 0;

   always #5 clk = ~clk;

   rx_char_buffer #(.DEPTH(DEPTH), .DW(DW), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
      .divisor(divisor), .line_fmt(line_fmt), .ref_tick(ref_tick),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
      .rd_pop(rd_pop), .lsr_rd(lsr_rd), .rd_data(rd_data),
      .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag),
      .timeout_irq(timeout_irq), .fill(fill)
   );

   // Behavioural reference model
   logic [DW-1:0] m_q[$];
   logic [DW-1:0] m_hold;
   bit m_hv, m_ovr, m_brk, m_tmo, m_mode;
   int m_cnt, m_frame, m_div;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q.delete(); m_hold = 0; m_hv = 0; m_ovr = 0; m_brk = 0;
         m_tmo = 0; m_mode = 0; m_cnt = 0; m_frame = 10; m_div = DEF_DIV;
      end else begin
         bit flush, pop_ok, ovr_ev, brk_clr, run, restart;
         int n0, lim;
         flush = fifo_clr || (fifo_en != m_mode);
         n0 = m_q.size();
         pop_ok = 0; ovr_ev = 0; brk_clr = 0;
         if (flush) begin
            m_q.delete(); m_hv = 0;
         end else if (m_mode) begin
            pop_ok = rd_pop && n0 > 0;
            if (rx_valid && n0 == DEPTH) ovr_ev = 1;
            if (pop_ok) begin void'(m_q.pop_front()); brk_clr = (n0 == 1); end
            if (rx_valid && n0 < DEPTH) m_q.push_back(rx_data);
         end else begin
            if (rx_valid) begin
               if (m_hv && !rd_pop) ovr_ev = 1;
               m_hold = rx_data; m_hv = 1;
            end else if (rd_pop) m_hv = 0;
         end
         run = m_mode && n0 != 0 && !flush;
         restart = (rx_valid && m_mode) || pop_ok;
         lim = 4 * m_frame * m_div;
         if (!run || restart) begin m_cnt = 0; m_tmo = 0; end
         else if (!m_tmo && ref_tick) begin
            if (m_cnt == lim - 1) m_tmo = 1; else m_cnt++;
         end
         if (divisor != 0) begin
            m_div = divisor;
            m_frame = 1 + 5 + line_fmt[1:0] + line_fmt[3] + (line_fmt[2] ? 2 : 1);
         end
         m_ovr = ovr_ev || (m_ovr && !lsr_rd);
         m_brk = rx_break || (m_brk && !lsr_rd && !brk_clr);
         m_mode = fifo_en;
      end
   end

   task automatic chk(string tag, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         bit dr;
         dr = m_mode ? (m_q.size() != 0) : m_hv;
         chk("R1 fill", fill, m_mode ? m_q.size() : 0);
         chk("R4 data_ready", data_ready, dr);
         if (dr) chk("R1 rd_data", rd_data, m_mode ? m_q[0] : m_hold);
         chk("R2 overrun", overrun, m_ovr);
         chk("R8 brk_flag", brk_flag, m_brk);
         chk("R5 timeout_irq", timeout_irq, m_tmo);
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic push(input logic [DW-1:0] b);
      rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
   endtask
   task automatic pop();
      rd_pop = 1; @(negedge clk); rd_pop = 0;
   endtask
   task automatic read_lsr();
      lsr_rd = 1; @(negedge clk); lsr_rd = 0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R11 reset state
      chk("R11 fill", fill, 0);
      chk("R11 data_ready", data_ready, 0);
      chk("R11 overrun", overrun, 0);
      chk("R11 timeout", timeout_irq, 0);
      rst_n = 1;
      wait_n(2);

      // R3 single-register overwrite
      push(8'h41);
      chk("R3 dr", data_ready, 1);
      push(8'h42);
      chk("R3 overrun", overrun, 1);
      chk("R3 data", rd_data, 8'h42);
      chk("R3 dr kept", data_ready, 1);
      read_lsr();
      chk("R8 overrun cleared", overrun, 0);
      // R10 no timeout in single-register mode
      wait_n(100);
      chk("R10 no timeout", timeout_irq, 0);
      pop();
      chk("R3 dr cleared by read", data_ready, 0);

      // R9 mode change flushes the holding register
      push(8'h55);
      fifo_en = 1; @(negedge clk);
      chk("R9 mode change dr", data_ready, 0);
      chk("R9 mode change fill", fill, 0);
      wait_n(1);

      // R1 ordering
      push(8'h10); push(8'h11); push(8'h12);
      chk("R1 fill 3", fill, 3);
      chk("R1 head", rd_data, 8'h10);
      pop();
      chk("R1 second", rd_data, 8'h11);
      pop(); pop();
      chk("R4 empty dr", data_ready, 0);

      // R2 full drop
      for (int i = 0; i < DEPTH; i++) push(8'(8'h80 + i));
      chk("R2 full", fill, DEPTH);
      push(8'hEE);
      chk("R2 overrun", overrun, 1);
      chk("R2 fill kept", fill, DEPTH);
      chk("R2 head kept", rd_data, 8'h80);
      read_lsr();
      chk("R8 lsr clears overrun", overrun, 0);
      for (int i = 0; i < DEPTH; i++) begin
         chk("R1 drain order", rd_data, 8'h80 + i);
         pop();
      end
      chk("R1 drained", fill, 0);

      // R5 timeout at 4*10*1 = 40 ticks
      push(8'h21);
      wait_n(39);
      chk("R5 not yet", timeout_irq, 0);
      wait_n(1);
      chk("R5 fired", timeout_irq, 1);
      push(8'h22);
      chk("R5 cleared by receive", timeout_irq, 0);
      pop();
      chk("R5 cleared by pop", timeout_irq, 0);
      pop();
      wait_n(60);
      chk("R10 empty no timeout", timeout_irq, 0);

      // R6 frame 1+8+1+2 = 12 -> 48 ticks
      line_fmt = 4'b1111; wait_n(2);
      push(8'h31);
      wait_n(47);
      chk("R6 not yet", timeout_irq, 0);
      wait_n(1);
      chk("R6 fired", timeout_irq, 1);
      pop();

      // R7 divisor 0 keeps settings: still 48 ticks
      divisor = 0; line_fmt = 4'b0000; wait_n(2);
      push(8'h32);
      wait_n(47);
      chk("R7 not yet", timeout_irq, 0);
      wait_n(1);
      chk("R7 fired", timeout_irq, 1);

      // R4 break cleared when last byte read
      rx_break = 1; @(negedge clk); rx_break = 0;
      chk("R4 brk set", brk_flag, 1);
      pop();
      chk("R4 brk cleared", brk_flag, 0);
      chk("R4 dr cleared", data_ready, 0);
      rx_break = 1; @(negedge clk); rx_break = 0;
      read_lsr();
      chk("R8 lsr clears brk", brk_flag, 0);

      // R9 explicit clear
      divisor = 1; line_fmt = 4'b0011;
      push(8'h61); push(8'h62);
      fifo_clr = 1; @(negedge clk); fifo_clr = 0;
      chk("R9 clear fill", fill, 0);
      chk("R9 clear dr", data_ready, 0);
      wait_n(4);

      summary();
      $finish;
   end
endmodule